// File: doc/BRIEF.md
# Shared-Ramp Single-Slope Converter Array

This block is the digital half of a bank of single-slope converters that all convert together. One counter runs in step with an external analogue ramp and is shared by every cell. Each cell has only its own comparator and its own latch. The comparator output enters the block as a digital flag that goes high when the ramp passes the sample held in that cell. On that rising edge the cell stores the current shared count.

A one-clock `start_i` pulse begins a conversion. The block pulses `ramp_rst_o` so that the ramp restarts, clears the counter, and then counts through all 2^N codes. When the counter reaches full scale, `done_o` pulses. Every latched word is then streamed out, one cell per clock, with a valid strobe and the cell index. The defaults give 10-bit resolution over 128 cells.

Top module: `wilk_adc_array`

## Requirements
- R1: During a conversion the shared count starts at zero and rises by exactly one on every clock, so every cell shares the same time scale.
- R2: A cell whose comparator is low in the previous clock and high in clock c of a conversion (c counted from 0) stores the code c. Every cell is judged independently in the same conversion.
- R3: An accepted `start_i` makes `ramp_rst_o` high for exactly one clock. That clock is conversion clock 0, in which the count is zero.
- R4: A conversion lasts exactly 2^NBITS clocks. `done_o` is high for one clock only, in the clock that follows the full-scale count.
- R5: A cell whose comparator never rises during a conversion reads back the all-ones code.
- R6: Only the first rising edge of a comparator in a conversion is captured. Later edges in the same conversion leave the stored code unchanged.
- R7: Readout begins in the same clock as `done_o`. It presents cells 0 to NCELLS-1 in index order, one per clock, with `rd_valid_o` high for exactly NCELLS clocks and `rd_data_o` holding that cell's code.
- R8: `start_i` is ignored while a conversion or a readout is in progress: no `ramp_rst_o` follows it and the sequence in progress is not disturbed.
- R9: After reset, `ramp_rst_o`, `done_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, in step with the ramp |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request pulse, taken only when idle |
| cmp_i | input | NCELLS | Per-cell comparator flags, high once the ramp passes the sample |
| ramp_rst_o | output | 1 | One-clock ramp restart at conversion start |
| done_o | output | 1 | One-clock pulse after the full-scale count |
| rd_valid_o | output | 1 | Readout word valid |
| rd_idx_o | output | $clog2(NCELLS) | Index of the cell being read out |
| rd_data_o | output | NBITS | Code latched by that cell |

## Verification
The bench builds the block with NBITS=4 and NCELLS=4. With these values one conversion takes 16 clocks, so the zero code, the full-scale code, cells that never flip, and the whole readout sweep are all reached in a few hundred cycles. Four cells are enough for one conversion to mix early, late, simultaneous and missing comparator edges. They also allow repeated pulses on a single cell and start requests that arrive in the middle of a conversion or a readout.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } wk_state_e;
endpackage

// File: rtl/wk_seq.sv
module wk_seq import wk_pkg::*; #(
  parameter int NBITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_last_i,
  output logic [NBITS-1:0] count_o,
  output logic             clear_o,
  output logic             conv_o,
  output logic             last_o,
  output logic             read_o,
  output logic             ramp_rst_o,
  output logic             done_o
);
  localparam logic [NBITS-1:0] FULL = {NBITS{1'b1}};

  wk_state_e        state_q;
  logic [NBITS-1:0] count_q;
  logic             ramp_q, done_q;

  assign clear_o = start_i && (state_q == ST_IDLE);
  assign conv_o  = (state_q == ST_CONV);
  assign read_o  = (state_q == ST_READ);
  assign last_o  = conv_o && (count_q == FULL);
  assign count_o = count_q;
  assign ramp_rst_o = ramp_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      ramp_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ramp_q <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CONV;
          count_q <= '0;
          ramp_q  <= 1'b1;
        end
        ST_CONV: begin
          count_q <= count_q + 1'b1;
          if (count_q == FULL) begin
            state_q <= ST_READ;
            done_q  <= 1'b1;
          end
        end
        ST_READ: if (rd_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  ramp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_rst_o |-> (conv_o && count_q == '0));
  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o && !last_o) |=> (conv_o && count_q == $past(count_q) + 1'b1));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(last_o) && read_o));
  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(state_q == ST_IDLE)) |=> !ramp_rst_o);
endmodule

// File: rtl/wk_cell.sv
module wk_cell #(
  parameter int NBITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             conv_i,
  input  logic             last_i,
  input  logic             cmp_i,
  input  logic [NBITS-1:0] count_i,
  output logic [NBITS-1:0] data_o
);
  localparam logic [NBITS-1:0] FULL = {NBITS{1'b1}};

  logic             cmp_q, got_q;
  logic [NBITS-1:0] data_q;
  logic             rise;

  assign rise   = cmp_i && !cmp_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= 1'b0;
      got_q  <= 1'b0;
      data_q <= '0;
    end else begin
      cmp_q <= cmp_i;
      if (clear_i) begin
        got_q <= 1'b0;
      end else if (conv_i && !got_q) begin
        if (rise) begin
          data_q <= count_i;
          got_q  <= 1'b1;
        end else if (last_i) begin
          data_q <= FULL;  // no crossing: saturate
          got_q  <= 1'b1;
        end
      end
    end
  end

  // R6
  hold_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (got_q && !clear_i) |=> $stable(data_q));
  // R5
  full_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !got_q && !rise && !clear_i) |=> (data_q == FULL));
endmodule

// File: rtl/wilk_adc_array.sv
module wilk_adc_array #(
  parameter int NBITS  = 10,
  parameter int NCELLS = 128,
  localparam int IDXW  = $clog2(NCELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NCELLS-1:0] cmp_i,
  output logic              ramp_rst_o,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [IDXW-1:0]   rd_idx_o,
  output logic [NBITS-1:0]  rd_data_o
);
  logic [NBITS-1:0] count;
  logic             clear, conv, last, read;
  logic [IDXW-1:0]  idx_q;
  logic             rd_last;
  logic [NBITS-1:0] cell_data [NCELLS];

  assign rd_last = read && (idx_q == IDXW'(NCELLS - 1));

  wk_seq #(.NBITS(NBITS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rd_last_i  (rd_last),
    .count_o    (count),
    .clear_o    (clear),
    .conv_o     (conv),
    .last_o     (last),
    .read_o     (read),
    .ramp_rst_o (ramp_rst_o),
    .done_o     (done_o)
  );

  for (genvar g = 0; g < NCELLS; g++) begin : g_cell
    wk_cell #(.NBITS(NBITS)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .conv_i  (conv),
      .last_i  (last),
      .cmp_i   (cmp_i[g]),
      .count_i (count),
      .data_o  (cell_data[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             idx_q <= '0;
    else if (!read)          idx_q <= '0;
    else if (!rd_last)       idx_q <= idx_q + 1'b1;
  end

  assign rd_valid_o = read;
  assign rd_idx_o   = idx_q;
  assign rd_data_o  = cell_data[idx_q];

  // R7
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_last) |=> (rd_valid_o && rd_idx_o == $past(rd_idx_o) + 1'b1));
  // R7
  rd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_valid_o && rd_idx_o == '0));
endmodule

// File: tb/wilk_adc_array_tb.sv
module wilk_adc_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int NC   = 4;
  localparam int IW   = $clog2(NC);
  localparam int FULL = (1 << NB) - 1;
  localparam int NEVER = 1 << NB;
  localparam int NVEC = 4;
  // comparator first-high clock per cell; NEVER = no crossing
  localparam int FLIP [NVEC][NC] = '{
    '{0, 5, 15, NEVER},
    '{NEVER, NEVER, NEVER, NEVER},
    '{7, 1, 12, 3},
    '{9, 9, 9, 9}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NC-1:0] cmp = '0;
  logic ramp_rst, done, rd_valid;
  logic [IW-1:0] rd_idx;
  logic [NB-1:0] rd_data;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wilk_adc_array #(.NBITS(NB), .NCELLS(NC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .ramp_rst_o(ramp_rst), .done_o(done), .rd_valid_o(rd_valid),
    .rd_idx_o(rd_idx), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse[i]: cell i high only at flip, then low, then high again 6 clocks later
  task automatic run_conv(input int fl [NC], input logic [NC-1:0] pulse,
                          input bit start_mid, input bit start_rd);
    int exp [NC];
    for (int i = 0; i < NC; i++) exp[i] = (fl[i] > FULL) ? FULL : fl[i];
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= FULL; c++) begin
      for (int i = 0; i < NC; i++)
        cmp[i] = pulse[i] ? (c == fl[i] || c >= fl[i] + 6) : (c >= fl[i]);
      if (c == 0) chk(ramp_rst == 1'b1, "R3 ramp pulse", int'(ramp_rst), 1);
      if (c == 1 || c == 6) chk(ramp_rst == 1'b0, "R3/R8 ramp single", int'(ramp_rst), 0);
      if (c == FULL) chk(done == 1'b0, "R4 no early done", int'(done), 0);
      start = start_mid && (c == 5);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R4 done after 2^N", int'(done), 1);
    for (int k = 0; k < NC; k++) begin
      if (k == 1) chk(done == 1'b0, "R4 done one clock", int'(done), 0);
      chk(rd_valid == 1'b1, "R7 valid", int'(rd_valid), 1);
      chk(int'(rd_idx) == k, "R7 index", int'(rd_idx), k);
      chk(int'(rd_data) == exp[k], "R2/R5/R6 code", int'(rd_data), exp[k]);
      start = start_rd && (k == 1);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    chk(rd_valid == 1'b0, "R7 valid ends", int'(rd_valid), 0);
    if (start_rd) chk(ramp_rst == 1'b0, "R8 start in readout", int'(ramp_rst), 0);
    cmp = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fl [NC];
    repeat (3) @(negedge clk);
    chk(ramp_rst == 1'b0, "R9 ramp reset", int'(ramp_rst), 0);
    chk(done == 1'b0, "R9 done reset", int'(done), 0);
    chk(rd_valid == 1'b0, "R9 valid reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < NC; i++) fl[i] = FLIP[v][i];
      run_conv(fl, '0, 1'b0, 1'b0);
    end
    // R6: repeated edges on cells 0 and 2
    fl = '{3, 8, 0, NEVER};
    run_conv(fl, 4'b0101, 1'b0, 1'b0);
    // R8: start during conversion and during readout
    fl = '{2, 14, 6, 11};
    run_conv(fl, '0, 1'b1, 1'b1);
    // R9: reset mid-conversion
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ramp_rst == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R9 async reset",
        int'({ramp_rst, done, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    fl = '{4, NEVER, 0, 15};
    run_conv(fl, '0, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule